// File: doc/BRIEF.md
# Decimal Floating-Point Adder

This block adds or subtracts two normalized decimal floating-point numbers. Each number is 24 BCD digits, 96 bits. Every operand field is a whole number of digits: a sign digit, an exponent sign digit, a four-digit exponent magnitude and an eighteen-digit significand. The decimal point sits after the first significand digit. The block converts the exponent to a biased binary value and works one significand digit per clock. It aligns the smaller operand by shifting right, adds or subtracts across a 37-digit working register that ends in a carry digit, and renormalizes. It then rounds the result to eighteen digits, to nearest, with ties going to even.

Operands come in over a valid/ready channel, and the result goes out over a second valid/ready channel. The block works on one operation at a time. `op_ready` is high only while the block is idle. An operation is taken on a clock edge where `op_valid` and `op_ready` are both high. The result, with `res_valid`, stays constant until the consumer raises `res_ready`. The block accepts no new operation before that result has been taken, so back-pressure on the result side stalls the operand side.

Top module: `dfp_adder`

## Requirements
- R1: Encoding, from the most significant end: bits [95:92] are the number's sign digit, bits [91:88] are the exponent sign digit, bits [87:72] hold four BCD exponent digits with the most significant digit first, and bits [71:0] hold eighteen BCD significand digits with the leading digit in [71:68]. A sign digit of 0 means plus and 1 means minus. Zero is encoded by an all-zero significand. Every result that is not in error has valid BCD digits.
- R2: `op_ready` is high only when the block is idle, so it is low while an operation runs and while a result is waiting. A result stays valid and unchanged until it is taken with `res_ready`, and an operation completes within a bounded number of cycles.
- R3: If one operand has a zero significand, the result is the other operand bit for bit. When that other operand is the second operand, its sign digit becomes the effective sign. If both operands are zero, the first operand is returned.
- R4: With `op_sub` high, the sign of the second operand is inverted and the two operands are then added.
- R5: When the effective signs are equal, the significands are added and the result takes the common sign. A carry out of the leading digit shifts the result right by one digit and raises the exponent by one.
- R6: When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. Leading zero digits are removed, one exponent step per digit.
- R7: Equal magnitudes with opposite effective signs give the all-zero encoding, which has a positive sign.
- R8: If the exponents differ by more than 18, the result is the larger-magnitude operand with its effective sign. A difference of exactly 18 still goes through alignment and rounding.
- R9: The rounded result keeps eighteen digits. Rounding is to nearest, and an exact half rounds toward an even last digit.
- R10: If rounding up carries out of the eighteenth digit, the significand becomes 1 followed by zeros and the exponent rises by one.
- R11: `range_err` is raised with the result when the result exponent is above +9999 or below -9999. It is never high without `res_valid`.
- R12: Every nonzero result that is not in error has a nonzero leading significand digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operand pair offered |
| op_ready | output | 1 | Block idle and able to take an operation |
| opa | input | 96 | First operand |
| opb | input | 96 | Second operand |
| op_sub | input | 1 | Subtract the second operand instead of adding it |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res | output | 96 | Normalized, rounded result |
| range_err | output | 1 | Result exponent out of range, valid with `res_valid` |

## Verification
The hardest case to reach from the ports is a rounding decision that depends on digits which exist only because of alignment. The smaller operand must be shifted by exactly eighteen digits, so that all of its significance falls into the discarded half of the working register. The bench reaches it with exponent pairs eighteen apart, choosing the low operand's leading digit to make the discarded part exactly half, above half, or below half. It also pairs these with high significands that end in odd or even digits, or that are all nines, to drive the tie-to-even path and the rounding carry. Exponent range errors are reached by adding operands at +9999 and by cancelling operands at -9999.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ALIGN = 3'd1,
    S_ADD   = 3'd2,
    S_NORM  = 3'd3,
    S_ROUND = 3'd4,
    S_DONE  = 3'd5
  } dfp_state_e;
endpackage

// File: rtl/dfp_digit_alu.sv
module dfp_digit_alu (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  input  logic       sub,
  output logic [3:0] d,
  output logic       cout
);
  logic [4:0] t;

  always_comb begin
    if (sub) begin
      t = 5'(a) - 5'(b) - 5'(cin);
      if (t[4]) begin
        d    = 4'(t + 5'd10);
        cout = 1'b1;
      end else begin
        d    = t[3:0];
        cout = 1'b0;
      end
    end else begin
      t = 5'(a) + 5'(b) + 5'(cin);
      if (t > 5'd9) begin
        d    = 4'(t - 5'd10);
        cout = 1'b1;
      end else begin
        d    = t[3:0];
        cout = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dfp_bcd_inc.sv
module dfp_bcd_inc #(
  parameter int NDIG = 18
) (
  input  logic [4*NDIG-1:0] v,
  input  logic              cin,
  output logic [4*NDIG-1:0] r,
  output logic              cout
);
  logic [NDIG:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] dg;
    assign dg = v[4*i +: 4];
    assign r[4*i +: 4] = !c[i] ? dg : ((dg == 4'd9) ? 4'd0 : dg + 4'd1);
    assign c[i+1] = c[i] && (dg == 4'd9);
  end

  assign cout = c[NDIG];
endmodule

// File: rtl/dfp_adder.sv
module dfp_adder #(
  parameter int NDIG = 18,
  parameter int EDIG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  output logic                      op_ready,
  input  logic [4*(NDIG+EDIG+2)-1:0] opa,
  input  logic [4*(NDIG+EDIG+2)-1:0] opb,
  input  logic                      op_sub,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [4*(NDIG+EDIG+2)-1:0] res,
  output logic                      range_err
);
  import dfp_pkg::*;

  localparam int W    = 4*(NDIG+EDIG+2);
  localparam int SW   = 4*NDIG;
  localparam int WD   = 2*NDIG+1;
  localparam int XW   = 4*WD;
  localparam int BIAS = 10**EDIG;
  localparam int EW   = $clog2(2*BIAS+XW)+2;
  localparam int CW   = $clog2(WD+1);

  function automatic logic signed [EW-1:0] to_biased(input logic [W-1:0] v);
    int m = 0;
    for (int i = EDIG-1; i >= 0; i--) m = m*10 + int'(v[SW+4*i +: 4]);
    if (v[W-8 +: 4] != 4'd0) m = -m;
    return EW'(m + BIAS);
  endfunction

  function automatic logic [W-1:0] pack(input logic neg, input logic signed [EW-1:0] e,
                                        input logic [SW-1:0] sig);
    logic [W-1:0] v;
    int m = int'(e) - BIAS;
    v = '0;
    v[W-4 +: 4] = {3'b0, neg};
    v[W-8 +: 4] = {3'b0, m < 0};
    if (m < 0) m = -m;
    for (int i = 0; i < EDIG; i++) begin
      v[SW+4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
    v[SW-1:0] = sig;
    return v;
  endfunction

  dfp_state_e state;
  logic [XW-1:0] x, y;
  logic [CW-1:0] cnt;
  logic carry, do_sub, rsign, err;
  logic signed [EW-1:0] rexp;
  logic [W-1:0] rres;

  // operand decode at the input channel
  logic sa, sb, za, zb, a_big;
  logic signed [EW-1:0] ea, eb, el, es, diff;
  logic [W-1:0] b_eff;
  assign sa    = opa[W-4 +: 4] != 4'd0;
  assign sb    = (opb[W-4 +: 4] != 4'd0) ^ op_sub;
  assign za    = opa[SW-1:0] == '0;
  assign zb    = opb[SW-1:0] == '0;
  assign ea    = to_biased(opa);
  assign eb    = to_biased(opb);
  assign a_big = (ea > eb) || (ea == eb && opa[SW-1:0] >= opb[SW-1:0]);
  assign el    = a_big ? ea : eb;
  assign es    = a_big ? eb : ea;
  assign diff  = el - es;
  assign b_eff = {3'b0, sb, opb[W-5:0]};

  // one digit of the serial add/subtract
  logic [3:0] alu_d;
  logic alu_co;
  dfp_digit_alu u_alu (
    .a(x[3:0]), .b(y[3:0]), .cin(carry), .sub(do_sub), .d(alu_d), .cout(alu_co)
  );

  // rounding of the upper half against the discarded half
  logic [SW-1:0] top, inc_r, fin_sig;
  logic [3:0] guard;
  logic rest, round_up, inc_co;
  logic signed [EW-1:0] fin_exp;
  assign top      = x[XW-5:SW];
  assign guard    = x[SW-1 -: 4];
  assign rest     = x[SW-5:0] != '0;
  assign round_up = (guard > 4'd5) || (guard == 4'd5 && (rest || top[0]));
  dfp_bcd_inc #(.NDIG(NDIG)) u_inc (.v(top), .cin(round_up), .r(inc_r), .cout(inc_co));
  assign fin_sig = inc_co ? {4'd1, {(SW-4){1'b0}}} : inc_r;
  assign fin_exp = rexp + EW'(inc_co);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      x      <= '0;
      y      <= '0;
      cnt    <= '0;
      carry  <= 1'b0;
      do_sub <= 1'b0;
      rsign  <= 1'b0;
      rexp   <= '0;
      rres   <= '0;
      err    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (op_valid) begin
          err <= 1'b0;
          if (zb) begin
            rres  <= opa;
            state <= S_DONE;
          end else if (za) begin
            rres  <= b_eff;
            state <= S_DONE;
          end else if (diff > EW'(NDIG)) begin
            rres  <= a_big ? opa : b_eff;
            state <= S_DONE;
          end else begin
            x      <= {4'h0, (a_big ? opa[SW-1:0] : opb[SW-1:0]), {SW{1'b0}}};
            y      <= {4'h0, (a_big ? opb[SW-1:0] : opa[SW-1:0]), {SW{1'b0}}};
            do_sub <= sa != sb;
            rsign  <= a_big ? sa : sb;
            rexp   <= el;
            carry  <= 1'b0;
            if (diff == '0) begin
              cnt   <= CW'(WD-1);
              state <= S_ADD;
            end else begin
              cnt   <= CW'(diff);
              state <= S_ALIGN;
            end
          end
        end
        S_ALIGN: begin
          y   <= y >> 4;
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            cnt   <= CW'(WD-1);
            state <= S_ADD;
          end
        end
        S_ADD: begin
          x     <= {alu_d, x[XW-1:4]};
          y     <= y >> 4;
          carry <= alu_co;
          cnt   <= cnt - 1'b1;
          if (cnt == '0) state <= S_NORM;
        end
        S_NORM: begin
          if (x == '0) begin
            rres  <= '0;
            state <= S_DONE;
          end else if (x[XW-1 -: 4] != 4'd0) begin
            x    <= x >> 4;
            rexp <= rexp + 1'b1;
          end else if (x[XW-5 -: 4] == 4'd0) begin
            x    <= x << 4;
            rexp <= rexp - 1'b1;
          end else begin
            state <= S_ROUND;
          end
        end
        S_ROUND: begin
          rres  <= pack(rsign, fin_exp, fin_sig);
          err   <= (fin_exp < EW'(1)) || (fin_exp > EW'(2*BIAS-1));
          state <= S_DONE;
        end
        S_DONE: if (res_ready) begin
          err   <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign op_ready  = state == S_IDLE;
  assign res_valid = state == S_DONE;
  assign res       = rres;
  assign range_err = err;
endmodule

// File: rtl/dfp_adder_chk.sv
module dfp_adder_chk #(
  parameter int NDIG = 18,
  parameter int EDIG = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       op_ready,
  input logic                       res_valid,
  input logic                       res_ready,
  input logic [4*(NDIG+EDIG+2)-1:0] res,
  input logic                       range_err
);
  localparam int W     = 4*(NDIG+EDIG+2);
  localparam int SW    = 4*NDIG;
  localparam int WD    = 2*NDIG+1;
  localparam int LIMIT = 3*WD + NDIG + 8;
  localparam int LW    = $clog2(LIMIT+2);

  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < W/4; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic [LW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (op_ready || res_valid) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 1'b1;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res) && $stable(range_err));

  p_no_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !op_ready);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt < LW'(LIMIT));

  p_digits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !range_err |-> all_bcd(res));

  p_lead_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !range_err && res[SW-1:0] != '0 |-> res[SW-1 -: 4] != 4'd0);

  p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> res_valid);
endmodule

bind dfp_adder dfp_adder_chk #(.NDIG(NDIG), .EDIG(EDIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res(res), .range_err(range_err)
);

// File: tb/dfp_adder_bench.sv
module dfp_adder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_sub = 1'b0, res_ready = 1'b0;
  logic [95:0] opa = '0, opb = '0;
  logic op_ready, res_valid, range_err;
  logic [95:0] res;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dfp_adder u_dfp_adder (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .opa(opa), .opb(opb), .op_sub(op_sub), .res_valid(res_valid),
    .res_ready(res_ready), .res(res), .range_err(range_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // R1 layout: sign, exponent sign, 4 exponent digits, 18 significand digits
  function automatic logic [95:0] enc(input bit neg, input int e, input logic [71:0] sig);
    logic [95:0] v;
    int m = (e < 0) ? -e : e;
    v[95:92] = {3'b0, neg};
    v[91:88] = {3'b0, e < 0};
    for (int i = 0; i < 4; i++) begin
      v[72+4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
    v[71:0] = sig;
    return v;
  endfunction

  task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [95:0] a, input logic [95:0] b, input bit s,
                        input int hold, output logic [95:0] r, output logic e);
    int n = 0;
    logic [95:0] first;
    @(negedge clk);
    opa = a; opb = b; op_sub = s; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    while (!res_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (!res_valid) begin
      checks++; fails++;
      $display("FAIL R2: no result, actual 0 expected 1");
    end
    first = res;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R2 hold valid", {95'b0, res_valid}, 96'd1);
      check("R2 hold value", res, first);
      check("R2 no accept while waiting", {95'b0, op_ready}, 96'd0);
    end
    r = res; e = range_err;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  localparam logic [71:0] ONE  = 72'h100000000000000000;
  localparam logic [71:0] NINE = 72'h999999999999999999;

  logic [95:0] r;
  logic e;

  task automatic t_reset();
    check("R2 reset ready", {95'b0, op_ready}, 96'd1);
    check("R2 reset valid", {95'b0, res_valid}, 96'd0);
  endtask

  task automatic t_same_sign();
    run_op(enc(0,0,ONE), enc(0,0,72'h200000000000000000), 0, 0, r, e);
    check("R5 plain sum", r, enc(0,0,72'h300000000000000000));
    check("R11 no error", {95'b0, e}, 96'd0);
    run_op(enc(0,0,72'h500000000000000000), enc(0,0,72'h500000000000000000), 0, 0, r, e);
    check("R5 carry digit", r, enc(0,1,ONE));
    run_op(enc(1,-3,72'h250000000000000000), enc(1,-3,72'h250000000000000000), 0, 0, r, e);
    check("R5 negative common sign", r, enc(1,-3,72'h500000000000000000));
  endtask

  task automatic t_subtract();
    run_op(enc(0,0,72'h500000000000000000), enc(0,0,72'h200000000000000000), 1, 0, r, e);
    check("R4 subtract", r, enc(0,0,72'h300000000000000000));
    run_op(enc(0,0,72'h200000000000000000), enc(0,0,72'h500000000000000000), 1, 0, r, e);
    check("R6 sign of larger", r, enc(1,0,72'h300000000000000000));
    run_op(enc(0,1,ONE), enc(0,0,ONE), 1, 0, r, e);
    check("R6 aligned borrow", r, enc(0,0,72'h900000000000000000));
    run_op(enc(0,0,72'h100000000000000001), enc(0,0,ONE), 1, 0, r, e);
    check("R6 leading zeros removed", r, enc(0,-17,ONE));
  endtask

  task automatic t_cancel();
    run_op(enc(1,2,72'h300000000000000000), enc(0,2,72'h300000000000000000), 0, 0, r, e);
    check("R7 exact cancel", r, 96'd0);
  endtask

  task automatic t_zero();
    run_op(96'd0, enc(0,3,72'h750000000000000000), 1, 0, r, e);
    check("R3 zero first operand", r, enc(1,3,72'h750000000000000000));
    run_op(enc(1,-5,72'h400000000000000000), 96'd0, 0, 0, r, e);
    check("R3 zero second operand", r, enc(1,-5,72'h400000000000000000));
  endtask

  task automatic t_trivial();
    run_op(enc(0,20,ONE), enc(0,0,NINE), 0, 0, r, e);
    check("R8 far smaller dropped", r, enc(0,20,ONE));
    run_op(enc(0,0,ONE), enc(0,19,72'h200000000000000000), 1, 0, r, e);
    check("R8 larger with flipped sign", r, enc(1,19,72'h200000000000000000));
  endtask

  task automatic t_round();
    run_op(enc(0,18,ONE), enc(0,0,72'h500000000000000000), 0, 0, r, e);
    check("R9 tie stays even", r, enc(0,18,ONE));
    run_op(enc(0,18,72'h100000000000000001), enc(0,0,72'h500000000000000000), 0, 0, r, e);
    check("R9 tie rounds to even", r, enc(0,18,72'h100000000000000002));
    run_op(enc(0,18,ONE), enc(0,0,72'h600000000000000000), 0, 0, r, e);
    check("R9 above half", r, enc(0,18,72'h100000000000000001));
    run_op(enc(0,18,ONE), enc(0,0,72'h400000000000000000), 0, 0, r, e);
    check("R9 below half", r, enc(0,18,ONE));
    run_op(enc(0,0,NINE), enc(0,0,NINE), 0, 0, r, e);
    check("R9 carry then round", r, enc(0,1,72'h200000000000000000));
  endtask

  task automatic t_round_carry();
    run_op(enc(0,18,NINE), enc(0,0,72'h600000000000000000), 0, 0, r, e);
    check("R10 rounding carry", r, enc(0,19,ONE));
  endtask

  task automatic t_range();
    run_op(enc(0,9999,72'h900000000000000000), enc(0,9999,72'h900000000000000000), 0, 0, r, e);
    check("R11 overflow flagged", {95'b0, e}, 96'd1);
    run_op(enc(0,9999,ONE), enc(0,9999,ONE), 0, 0, r, e);
    check("R11 top exponent fine", r, enc(0,9999,72'h200000000000000000));
    check("R11 top exponent no error", {95'b0, e}, 96'd0);
    run_op(enc(0,-9999,72'h100000000000000001), enc(0,-9999,ONE), 1, 0, r, e);
    check("R11 underflow flagged", {95'b0, e}, 96'd1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    opa = enc(0,0,ONE); opb = enc(0,0,ONE); op_sub = 0; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R2 busy not ready", {95'b0, op_ready}, 96'd0);
    while (!res_valid) @(negedge clk);
    run_op(enc(0,0,ONE), enc(0,0,ONE), 0, 0, r, e);
    check("R2 queued value held", r, enc(0,0,72'h200000000000000000));
    run_op(enc(0,4,72'h123000000000000000), enc(0,2,72'h100000000000000000), 0, 5, r, e);
    check("R2 value after stall", r, enc(0,4,72'h124000000000000000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_same_sign();
    t_subtract();
    t_cancel();
    t_zero();
    t_trivial();
    t_round();
    t_round_carry();
    t_range();
    t_backpressure();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule